// File: doc/BRIEF.md
# Load-Multiple-Word Sequencer

This block carries out a load-multiple-word operation over several clock cycles. After a start pulse it fills general-purpose registers one after another, beginning at a given register number and finishing with register 31. Each register receives one 32-bit word from memory, zero-extended to 64 bits. The memory address starts at an effective address that is computed upstream and grows by four bytes for each register.

The controller reads memory through a simple request/ready handshake. The read data is valid in the same cycle that ready is high. Each returned word is presented one cycle later on a single register-file write port. A one-cycle done pulse follows the last write. While a sequence is running, busy stays high and any further start pulses are ignored.

Top module: `lmw_seq`

## Requirements
- R1: A start pulse seen while idle latches the start register number and the base address. The first memory read goes to the base address, and the first register write targets the start register.
- R2: Register writes go to consecutive indices in increasing order. The last write is to register 31, so exactly 32 minus the start index writes occur.
- R3: Every written value has bits 63:32 equal to zero and bits 31:0 equal to the memory word returned for that register.
- R4: The read address for the k-th register of a sequence (k counted from 0) is the base address plus 4·k, modulo 2^32.
- R5: A start with register number 31 performs exactly one memory read and one register write.
- R6: A memory request stays asserted with a stable address until ready is seen. Data on mem_data_i counts only in a cycle where both request and ready are high. The register write for that word occurs in the following cycle.
- R7: busy_o is high from the cycle after an accepted start through the done cycle. Start pulses while busy have no effect on the running sequence, and no new sequence begins from them.
- R8: done_o is high for exactly one cycle, in the cycle immediately after the write to register 31.
- R9: A synchronous reset, including one applied mid-sequence, returns the block to idle with request, write enable, busy and done all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Start pulse |
| start_reg_i | input | 5 | First register number to load |
| base_addr_i | input | 32 | Effective address of the first word |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | 32 | Memory read byte address |
| mem_ready_i | input | 1 | Read data valid / request accepted |
| mem_data_i | input | 32 | Read data word |
| rf_we_o | output | 1 | Register write enable |
| rf_idx_o | output | 5 | Register write index |
| rf_data_o | output | 64 | Register write data |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench targets the following corner cases:
- A start at register 31. A loop that tests its end condition in the wrong place would read twice or wrap around to register 0.
- A start at register 0 and a base address near the top of the address space. An off-by-one step or a truncated address would show up as a wrong read address or a wrong data word.
- Random ready delays, with junk on the data lines while ready is low. A design that dropped its request or captured data early would be caught.
- Start pulses sprayed throughout a busy sequence and during the done cycle. A design that restarts would skew the index order.
- A reset applied in the middle of a run, which must leave everything idle.

// File: rtl/lmw_pkg.sv
package lmw_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WR   = 2'd2,
        ST_FIN  = 2'd3
    } lmw_state_e;

endpackage

// File: rtl/lmw_addr_step.sv
// Next read address: current address plus one word in bytes.
module lmw_addr_step #(
    parameter int AW   = 32,
    parameter int STEP = 4
) (
    input  logic [AW-1:0] cur_i,
    output logic [AW-1:0] nxt_o
);
    always_comb begin
        nxt_o = cur_i + AW'(STEP);
    end
endmodule

// File: rtl/lmw_idx_track.sv
// Register index stepping and end-of-range detection.
module lmw_idx_track #(
    parameter int IDX_W = 5,
    parameter int LAST  = 31
) (
    input  logic [IDX_W-1:0] idx_i,
    output logic             is_last_o,
    output logic [IDX_W-1:0] nxt_o
);
    always_comb begin
        is_last_o = (idx_i == IDX_W'(LAST));
        nxt_o     = idx_i + IDX_W'(1);
    end
endmodule

// File: rtl/lmw_word_fmt.sv
// Widens a memory word to register width; SIGNED picks sign or zero fill.
module lmw_word_fmt #(
    parameter int WORD_W = 32,
    parameter int XLEN   = 64,
    parameter bit SIGNED = 1'b0
) (
    input  logic [WORD_W-1:0] word_i,
    output logic [XLEN-1:0]   val_o
);
    localparam int FILL_W = XLEN - WORD_W;

    generate
        if (SIGNED) begin : g_sext
            always_comb val_o = {{FILL_W{word_i[WORD_W-1]}}, word_i};
        end else begin : g_zext
            always_comb val_o = {{FILL_W{1'b0}}, word_i};
        end
    endgenerate
endmodule

// File: rtl/lmw_seq.sv
module lmw_seq #(
    parameter int XLEN   = 64,
    parameter int WORD_W = 32,
    parameter int NREG   = 32,
    parameter int AW     = 32
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start_i,
    input  logic [$clog2(NREG)-1:0] start_reg_i,
    input  logic [AW-1:0]           base_addr_i,
    output logic                    mem_req_o,
    output logic [AW-1:0]           mem_addr_o,
    input  logic                    mem_ready_i,
    input  logic [WORD_W-1:0]       mem_data_i,
    output logic                    rf_we_o,
    output logic [$clog2(NREG)-1:0] rf_idx_o,
    output logic [XLEN-1:0]         rf_data_o,
    output logic                    busy_o,
    output logic                    done_o
);
    import lmw_pkg::*;

    localparam int IDX_W = $clog2(NREG);
    localparam int LAST  = NREG - 1;
    localparam int STEP  = WORD_W / 8;

    typedef struct packed {
        lmw_state_e        st;
        logic [IDX_W-1:0]  idx;
        logic [AW-1:0]     addr;
        logic [WORD_W-1:0] word;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [AW-1:0]    addr_nxt;
    logic [IDX_W-1:0] idx_nxt;
    logic             idx_last;

    lmw_addr_step #(.AW(AW), .STEP(STEP)) u_addr (
        .cur_i (ctl_q.addr),
        .nxt_o (addr_nxt)
    );

    lmw_idx_track #(.IDX_W(IDX_W), .LAST(LAST)) u_idx (
        .idx_i     (ctl_q.idx),
        .is_last_o (idx_last),
        .nxt_o     (idx_nxt)
    );

    lmw_word_fmt #(.WORD_W(WORD_W), .XLEN(XLEN), .SIGNED(1'b0)) u_fmt (
        .word_i (ctl_q.word),
        .val_o  (rf_data_o)
    );

    always_comb begin
        ctl_d = ctl_q;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    ctl_d.st   = ST_REQ;
                    ctl_d.idx  = start_reg_i;
                    ctl_d.addr = base_addr_i;
                end
            end
            ST_REQ: begin
                if (mem_ready_i) begin
                    ctl_d.word = mem_data_i;
                    ctl_d.st   = ST_WR;
                end
            end
            ST_WR: begin
                if (idx_last) begin
                    ctl_d.st = ST_FIN;
                end else begin
                    ctl_d.st   = ST_REQ;
                    ctl_d.idx  = idx_nxt;
                    ctl_d.addr = addr_nxt;
                end
            end
            ST_FIN: begin
                ctl_d.st = ST_IDLE;
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    always_comb begin
        mem_req_o  = (ctl_q.st == ST_REQ);
        mem_addr_o = ctl_q.addr;
        rf_we_o    = (ctl_q.st == ST_WR);
        rf_idx_o   = ctl_q.idx;
        busy_o     = (ctl_q.st != ST_IDLE);
        done_o     = (ctl_q.st == ST_FIN);
    end
endmodule

// File: rtl/lmw_seq_chk.sv
module lmw_seq_chk #(
    parameter int XLEN   = 64,
    parameter int WORD_W = 32,
    parameter int NREG   = 32,
    parameter int AW     = 32
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    mem_req_o,
    input logic [AW-1:0]           mem_addr_o,
    input logic                    mem_ready_i,
    input logic                    rf_we_o,
    input logic [$clog2(NREG)-1:0] rf_idx_o,
    input logic [XLEN-1:0]         rf_data_o,
    input logic                    busy_o,
    input logic                    done_o
);
    localparam int IDX_W = $clog2(NREG);
    localparam int LAST  = NREG - 1;

    logic             seen_q;
    logic [IDX_W-1:0] last_idx_q;

    always_ff @(posedge clk) begin
        if (rst || done_o) begin
            seen_q <= 1'b0;
        end else if (rf_we_o) begin
            seen_q <= 1'b1;
        end
        if (rf_we_o) begin
            last_idx_q <= rf_idx_o;
        end
    end

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        mem_req_o && !mem_ready_i |=> mem_req_o && $stable(mem_addr_o)); // R6

    AST_WRITE_AFTER_DATA: assert property (@(posedge clk) disable iff (rst)
        rf_we_o |-> $past(mem_req_o && mem_ready_i)); // R6

    AST_INDEX_ORDER: assert property (@(posedge clk) disable iff (rst)
        rf_we_o && seen_q |-> rf_idx_o == last_idx_q + IDX_W'(1)); // R2

    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        rf_we_o |-> rf_data_o[XLEN-1:WORD_W] == '0); // R3

    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
        done_o |-> $past(rf_we_o && rf_idx_o == IDX_W'(LAST))); // R8

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o && !busy_o); // R8

    AST_ACTIVE_BUSY: assert property (@(posedge clk) disable iff (rst)
        (mem_req_o || rf_we_o || done_o) |-> busy_o); // R7

    AST_ONE_PHASE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({mem_req_o, rf_we_o, done_o})); // R7

    AST_RESET_IDLE: assert property (@(posedge clk)
        $past(rst) |-> !busy_o && !rf_we_o && !mem_req_o && !done_o); // R9
endmodule

bind lmw_seq lmw_seq_chk #(
    .XLEN(XLEN), .WORD_W(WORD_W), .NREG(NREG), .AW(AW)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .mem_req_o   (mem_req_o),
    .mem_addr_o  (mem_addr_o),
    .mem_ready_i (mem_ready_i),
    .rf_we_o     (rf_we_o),
    .rf_idx_o    (rf_idx_o),
    .rf_data_o   (rf_data_o),
    .busy_o      (busy_o),
    .done_o      (done_o)
);

// File: tb/lmw_seq_test.sv
`timescale 1ns/1ps
module lmw_seq_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        start_i;
    logic [4:0]  start_reg_i;
    logic [31:0] base_addr_i;
    logic        mem_req_o;
    logic [31:0] mem_addr_o;
    logic        mem_ready_i;
    logic [31:0] mem_data_i;
    logic        rf_we_o;
    logic [4:0]  rf_idx_o;
    logic [63:0] rf_data_o;
    logic        busy_o;
    logic        done_o;

    int total = 0;
    int failed = 0;

    always #2 clk = ~clk;

    lmw_seq uut (
        .clk(clk), .rst(rst), .start_i(start_i), .start_reg_i(start_reg_i),
        .base_addr_i(base_addr_i), .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
        .mem_ready_i(mem_ready_i), .mem_data_i(mem_data_i), .rf_we_o(rf_we_o),
        .rf_idx_o(rf_idx_o), .rf_data_o(rf_data_o), .busy_o(busy_o), .done_o(done_o)
    );

    function automatic logic [31:0] memf(input logic [31:0] a);
        return (a * 32'h9E3779B1) ^ 32'hA5C3_0F96;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            failed++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic idle_chk(input string tag);
        chk(!busy_o && !rf_we_o && !mem_req_o && !done_o, tag,
            {60'h0, busy_o, rf_we_o, mem_req_o, done_o}, 64'h0);
    endtask

    task automatic run_seq(input int first, input logic [31:0] base, input bit noise);
        int          exp_idx = first;
        int          writes = 0;
        int          reads = 0;
        int          cyc = 0;
        logic [31:0] exp_addr = base;
        bit          prev_rdy = 0, prev_wait = 0, prev_we = 0, fin = 0, rdy;
        logic [4:0]  prev_idx = '0;
        logic [31:0] prev_addr = '0;
        @(negedge clk);
        start_i = 1'b1; start_reg_i = 5'(first); base_addr_i = base;
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o, "R7 busy after start", 64'(busy_o), 64'h1);
        chk(mem_req_o && mem_addr_o == base, "R1 first read at base", 64'(mem_addr_o), 64'(base));
        while (!fin && cyc < 3000) begin
            if (prev_wait)
                chk(mem_req_o && mem_addr_o == prev_addr, "R6 request held", 64'(mem_addr_o), 64'(prev_addr));
            if (mem_req_o)
                chk(mem_addr_o == exp_addr, "R4 read address", 64'(mem_addr_o), 64'(exp_addr));
            if (rf_we_o) begin
                chk(prev_rdy, "R6 write only after data", 64'(prev_rdy), 64'h1);
                chk(rf_idx_o == 5'(exp_idx), (writes == 0) ? "R1 first index" : "R2 index order",
                    64'(rf_idx_o), 64'(exp_idx));
                chk(rf_data_o == {32'h0, memf(exp_addr)}, "R3 write data", rf_data_o, {32'h0, memf(exp_addr)});
                writes++; exp_idx++; exp_addr += 32'd4;
            end
            if (done_o) begin
                chk(prev_we && prev_idx == 5'd31, "R8 done after last write", 64'(prev_idx), 64'd31);
                chk(writes == 32 - first, "R2 write count", 64'(writes), 64'(32 - first));
                if (first == 31)
                    chk(reads == 1 && writes == 1, "R5 single read and write", 64'(reads), 64'h1);
                fin = 1;
            end else begin
                chk(busy_o, "R7 busy held", 64'(busy_o), 64'h1);
            end
            prev_we = rf_we_o; prev_idx = rf_idx_o;
            prev_rdy = 0; prev_wait = 0;
            if (mem_req_o) begin
                rdy = ($urandom % 3 == 0);
                mem_ready_i = rdy;
                mem_data_i = rdy ? memf(mem_addr_o) : $urandom;
                prev_rdy = rdy; prev_wait = !rdy; prev_addr = mem_addr_o;
                if (rdy) reads++;
            end else begin
                mem_ready_i = 1'($urandom % 2);
                mem_data_i = $urandom;
            end
            if (noise) begin
                start_i = ($urandom % 3 == 0);
                start_reg_i = 5'($urandom);
                base_addr_i = $urandom;
            end
            @(negedge clk);
            cyc++;
        end
        start_i = 1'b0; mem_ready_i = 1'b0;
        chk(fin, "R8 done reached", 64'(fin), 64'h1);
        idle_chk("R8 done lasts one cycle");
        @(negedge clk);
        idle_chk("R7 start while busy ignored");
    endtask

    initial begin
        void'($urandom(32'd2024));
        rst = 1'b1; start_i = 1'b0; start_reg_i = '0; base_addr_i = '0;
        mem_ready_i = 1'b0; mem_data_i = '0;
        repeat (3) @(negedge clk);
        idle_chk("R9 reset state");
        rst = 1'b0;
        @(negedge clk);
        idle_chk("R9 idle after reset");

        run_seq(31, 32'h0000_1000, 1'b0);
        run_seq(0, 32'h0000_2000, 1'b0);
        run_seq(30, 32'h0000_0123, 1'b1);
        run_seq(29, 32'hFFFF_FFF8, 1'b0);
        for (int i = 0; i < 10; i++)
            run_seq(int'($urandom % 32), $urandom, 1'(i % 2));

        // mid-sequence reset
        @(negedge clk);
        start_i = 1'b1; start_reg_i = 5'd0; base_addr_i = 32'h4000;
        @(negedge clk);
        start_i = 1'b0;
        for (int k = 0; k < 9; k++) begin
            mem_ready_i = mem_req_o;
            mem_data_i = memf(mem_addr_o);
            @(negedge clk);
        end
        rst = 1'b1; mem_ready_i = 1'b0;
        @(negedge clk);
        idle_chk("R9 reset mid-sequence");
        rst = 1'b0;
        @(negedge clk);
        idle_chk("R9 stays idle after reset");
        run_seq(27, 32'h0000_8000, 1'b1);

        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++; failed++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end
endmodule